// File: doc/BRIEF.md
# MDIO-Managed Ethernet PHY Register Bank

This block is the station-management side of a 10/100 Ethernet PHY model. A management controller reaches it over a two-wire serial link: a management clock (MDC) and one bidirectional data line (MDIO). The block decodes read and write frames from that link, checks the 5-bit PHY address against its own strapped address and against the broadcast address zero, and on a read drives the selected 16-bit register word back on the data line after the turnaround.

Behind the serial slave sits a 32-entry space of 16-bit registers. Only the basic control word, the basic status word, the two identifier words, the advertisement word, the partner-ability word, the expansion word and a vendor address/status word are populated. Link, negotiation and fault conditions come in as ports; the control word goes out as a port so the rest of the PHY model can act on loopback, speed, power-down and isolate. The PHY address is captured from strap inputs while reset is held. The MDC input is oversampled in the system clock domain; MDIO is taken on each detected MDC rising edge.

Top module: `mdio_phy_regs`

## Requirements
- R1: A frame is accepted only after at least 32 consecutive ones on MDIO followed by the start pair 0 then 1; the next 12 bits are the opcode (10 = read, 01 = write), the PHY address and the register address, each most significant bit first. A shorter preamble causes the frame to be ignored.
- R2: On a read, `mdio_oe` stays low for the first turnaround bit, then the block drives 0 for the second turnaround bit, then the 16 data bits most significant first, one per MDC rising edge, and releases the line on the MDC rising edge after the last data bit.
- R3: The block answers frames addressed to its latched PHY address or to 00000; a frame with any other address neither writes a register nor drives MDIO.
- R4: The 5-bit PHY address is captured from `strap_addr` while `rst_n` is low and reads back in register 25 bits 4:0; register 25 bit 6 reports `speed_10` and bit 5 reports `disconnected`, other bits read 0.
- R5: When the latched PHY address is 00000, register 0 bit 10 (isolate) reads 1 and cannot be cleared by a write.
- R6: Register 0 resets to 0x3000 (bit 13 speed = 100 Mb/s, bit 12 negotiation enable); bits 15:7 are writable and bits 6:0 always read 0; `ctrl_word` shows the register 0 value.
- R7: Writing 1 to register 0 bit 15 returns registers 0 and 4 to their reset values one clock later, and bit 15 then reads 0.
- R8: Register 0 bit 9 (restart negotiation) reads 1 for one clock after being written and then clears itself.
- R9: Register 1 reads bits 15:11 = 01111 (ability mask), bits 10:6 = 0, bit 5 = `an_complete`, bit 4 = `remote_fault`, bit 3 = 1, bit 2 = latched link, bit 1 = `jabber`, bit 0 = 1; writes to it have no effect.
- R10: The register 1 link bit is latched low: it reads 0 after reset or after any cycle with `link_up` low, and is reloaded from `link_up` when register 1 is read.
- R11: Register 4 resets to 0x01E1 with write mask 0xA3FF; registers 2 and 3 return the identifier parameters, register 5 returns `lp_ability`, register 6 returns `lp_nway` in bit 0.
- R12: Every register other than 0 to 6 and 25 reads 0, and writes to registers other than 0 and 4 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples MDC |
| rst_n | input | 1 | Active-low reset; address straps sampled while low |
| strap_addr | input | 5 | PHY address strap pins |
| mdc | input | 1 | Management serial clock |
| mdio_i | input | 1 | Management data line, input side |
| mdio_o | output | 1 | Management data line, output value |
| mdio_oe | output | 1 | Output enable for the data line tristate |
| link_up | input | 1 | Current link state from the line side |
| an_complete | input | 1 | Negotiation complete flag |
| remote_fault | input | 1 | Remote fault flag |
| jabber | input | 1 | Jabber condition flag |
| lp_ability | input | 16 | Link partner ability word |
| lp_nway | input | 1 | Partner supports negotiation |
| speed_10 | input | 1 | Resolved speed is 10 Mb/s |
| disconnected | input | 1 | Disconnect function status |
| ctrl_word | output | 16 | Current control register value |

## Verification
The assertions watch on every cycle that the reserved control bits stay zero, that the reset and restart bits clear themselves after one clock, that isolate is held while the strapped address is zero, that the latched address does not move outside reset and that the first driven turnaround bit is zero. Frame decoding, address matching, the latch-low link bit, write masks, ignored writes to read-only and reserved words, and the exact bit timing of read data can only be shown by the bench's serial frames, which compare every returned word against values derived from the requirements.

// File: rtl/mdio_phy_pkg.sv
package mdio_phy_pkg;

    typedef enum logic [2:0] {
        SER_PRE,
        SER_ST1,
        SER_HDR,
        SER_TA1,
        SER_TA2,
        SER_RDAT,
        SER_WTA,
        SER_WDAT
    } ser_state_t;

    localparam logic [1:0] OPC_READ  = 2'b10;
    localparam logic [1:0] OPC_WRITE = 2'b01;

    localparam int IDX_CTRL  = 0;
    localparam int IDX_STAT  = 1;
    localparam int IDX_ID_HI = 2;
    localparam int IDX_ID_LO = 3;
    localparam int IDX_ADV   = 4;
    localparam int IDX_LPAR  = 5;
    localparam int IDX_EXP   = 6;
    localparam int IDX_VADDR = 25;

endpackage

// File: rtl/mdio_serial_slave.sv
module mdio_serial_slave
    import mdio_phy_pkg::*;
#(
    parameter int PRE_LEN = 32,
    parameter int AW      = 5,
    parameter int DW      = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mdc,
    input  logic          mdio_i,
    input  logic [AW-1:0] my_addr,
    input  logic [DW-1:0] rd_data,
    output logic [AW-1:0] reg_addr,
    output logic          rd_stb,
    output logic          wr_stb,
    output logic [DW-1:0] wr_data,
    output logic          mdio_o,
    output logic          mdio_oe
);

    localparam int HDR_BITS = 2 + 2 * AW;
    localparam int CW       = $clog2(PRE_LEN + 1);

    typedef struct packed {
        ser_state_t    st;
        logic [CW-1:0] cnt;
        logic [DW-1:0] sh;
        logic [AW-1:0] rsel;
        logic          oe;
        logic          dout;
        logic          mdc_prev;
        logic          rd_stb;
        logic          wr_stb;
    } ser_t;

    ser_t q, n;
    logic rise;
    logic [1:0]    hdr_op;
    logic [AW-1:0] hdr_phy;
    logic          hdr_hit;

    assign rise = mdc & ~q.mdc_prev;

    always_comb begin
        n          = q;
        n.mdc_prev = mdc;
        n.rd_stb   = 1'b0;
        n.wr_stb   = 1'b0;
        hdr_op     = '0;
        hdr_phy    = '0;
        hdr_hit    = 1'b0;
        if (rise) begin
            unique case (q.st)
                SER_PRE: begin
                    if (mdio_i) begin
                        if (q.cnt < CW'(PRE_LEN)) n.cnt = q.cnt + 1'b1;
                    end else begin
                        n.st  = (q.cnt == CW'(PRE_LEN)) ? SER_ST1 : SER_PRE;
                        n.cnt = '0;
                    end
                end
                SER_ST1: begin
                    n.cnt = '0;
                    n.st  = mdio_i ? SER_HDR : SER_PRE;
                end
                SER_HDR: begin
                    n.sh  = {q.sh[DW-2:0], mdio_i};
                    n.cnt = q.cnt + 1'b1;
                    if (q.cnt == CW'(HDR_BITS - 1)) begin
                        hdr_op  = n.sh[2*AW+1 -: 2];
                        hdr_phy = n.sh[2*AW-1 -: AW];
                        hdr_hit = (hdr_phy == my_addr) || (hdr_phy == '0);
                        n.rsel  = n.sh[AW-1:0];
                        n.cnt   = '0;
                        if (hdr_hit && hdr_op == OPC_READ)       n.st = SER_TA1;
                        else if (hdr_hit && hdr_op == OPC_WRITE) n.st = SER_WTA;
                        else                                     n.st = SER_PRE;
                    end
                end
                SER_TA1: begin
                    n.st     = SER_TA2;
                    n.oe     = 1'b1;
                    n.dout   = 1'b0;
                    n.sh     = rd_data;
                    n.rd_stb = 1'b1;
                end
                SER_TA2: begin
                    n.st   = SER_RDAT;
                    n.dout = q.sh[DW-1];
                    n.sh   = {q.sh[DW-2:0], 1'b0};
                    n.cnt  = '0;
                end
                SER_RDAT: begin
                    if (q.cnt == CW'(DW - 1)) begin
                        n.st   = SER_PRE;
                        n.oe   = 1'b0;
                        n.dout = 1'b0;
                        n.cnt  = '0;
                    end else begin
                        n.dout = q.sh[DW-1];
                        n.sh   = {q.sh[DW-2:0], 1'b0};
                        n.cnt  = q.cnt + 1'b1;
                    end
                end
                SER_WTA: begin
                    if (q.cnt == CW'(1)) begin
                        n.st  = SER_WDAT;
                        n.cnt = '0;
                    end else begin
                        n.cnt = q.cnt + 1'b1;
                    end
                end
                SER_WDAT: begin
                    n.sh = {q.sh[DW-2:0], mdio_i};
                    if (q.cnt == CW'(DW - 1)) begin
                        n.wr_stb = 1'b1;
                        n.st     = SER_PRE;
                        n.cnt    = '0;
                    end else begin
                        n.cnt = q.cnt + 1'b1;
                    end
                end
                default: n.st = SER_PRE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st       <= SER_PRE;
            q.cnt      <= '0;
            q.sh       <= '0;
            q.rsel     <= '0;
            q.oe       <= 1'b0;
            q.dout     <= 1'b0;
            q.mdc_prev <= 1'b0;
            q.rd_stb   <= 1'b0;
            q.wr_stb   <= 1'b0;
        end else begin
            q <= n;
        end
    end

    assign reg_addr = q.rsel;
    assign rd_stb   = q.rd_stb;
    assign wr_stb   = q.wr_stb;
    assign wr_data  = q.sh;
    assign mdio_o   = q.dout;
    assign mdio_oe  = q.oe;

endmodule

// File: rtl/phy_reg_bank.sv
module phy_reg_bank
    import mdio_phy_pkg::*;
#(
    parameter int            AW         = 5,
    parameter int            DW         = 16,
    parameter logic [DW-1:0] CTRL_DEF   = 16'h3000,
    parameter logic [DW-1:0] CTRL_WMASK = 16'hFF80,
    parameter logic [DW-1:0] ADV_DEF    = 16'h01E1,
    parameter logic [DW-1:0] ADV_WMASK  = 16'hA3FF,
    parameter logic [DW-1:0] ID_HI      = 16'h2000,
    parameter logic [DW-1:0] ID_LO      = 16'h5C01,
    parameter logic [4:0]    ABILITY    = 5'b01111,
    parameter int            RST_BIT    = 15,
    parameter int            RESTART_BIT = 9,
    parameter int            ISO_BIT    = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] strap_addr,
    input  logic [AW-1:0] reg_addr,
    input  logic          rd_stb,
    input  logic          wr_stb,
    input  logic [DW-1:0] wr_data,
    input  logic          link_up,
    input  logic          an_complete,
    input  logic          remote_fault,
    input  logic          jabber,
    input  logic [DW-1:0] lp_ability,
    input  logic          lp_nway,
    input  logic          speed_10,
    input  logic          disconnected,
    output logic [DW-1:0] rd_data,
    output logic [DW-1:0] ctrl_word,
    output logic [AW-1:0] my_addr
);

    localparam int NREG = 1 << AW;

    typedef struct packed {
        logic [DW-1:0] ctrl;
        logic [DW-1:0] adv;
        logic          link_lat;
        logic [AW-1:0] addr;
    } bank_t;

    bank_t q, n;
    logic [DW-1:0] words [NREG];
    logic [DW-1:0] iso_force;

    assign iso_force = (q.addr == '0) ? (DW'(1) << ISO_BIT) : '0;
    assign ctrl_word = q.ctrl | iso_force;
    assign my_addr   = q.addr;

    always_comb begin
        n = q;
        if (q.ctrl[RST_BIT]) begin
            n.ctrl = CTRL_DEF;
            n.adv  = ADV_DEF;
        end else begin
            n.ctrl[RESTART_BIT] = 1'b0;
            if (wr_stb) begin
                if (reg_addr == AW'(IDX_CTRL)) n.ctrl = wr_data & CTRL_WMASK;
                if (reg_addr == AW'(IDX_ADV))  n.adv  = wr_data & ADV_WMASK;
            end
        end
        if (rd_stb && reg_addr == AW'(IDX_STAT)) n.link_lat = link_up;
        else if (!link_up)                        n.link_lat = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.ctrl     <= CTRL_DEF;
            q.adv      <= ADV_DEF;
            q.link_lat <= 1'b0;
            q.addr     <= strap_addr;
        end else begin
            q <= n;
        end
    end

    generate
        for (genvar gi = 0; gi < NREG; gi++) begin : g_word
            if (gi == IDX_CTRL) begin : g_ctrl
                assign words[gi] = ctrl_word;
            end else if (gi == IDX_STAT) begin : g_stat
                assign words[gi] = {ABILITY, 5'b0, an_complete, remote_fault,
                                    1'b1, q.link_lat, jabber, 1'b1};
            end else if (gi == IDX_ID_HI) begin : g_idh
                assign words[gi] = ID_HI;
            end else if (gi == IDX_ID_LO) begin : g_idl
                assign words[gi] = ID_LO;
            end else if (gi == IDX_ADV) begin : g_adv
                assign words[gi] = q.adv;
            end else if (gi == IDX_LPAR) begin : g_lpar
                assign words[gi] = lp_ability;
            end else if (gi == IDX_EXP) begin : g_exp
                assign words[gi] = {{(DW-1){1'b0}}, lp_nway};
            end else if (gi == IDX_VADDR) begin : g_vaddr
                assign words[gi] = {{(DW-AW-2){1'b0}}, speed_10, disconnected, q.addr};
            end else begin : g_zero
                assign words[gi] = '0;
            end
        end
    endgenerate

    assign rd_data = words[reg_addr];

endmodule

// File: rtl/mdio_phy_regs.sv
module mdio_phy_regs (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [4:0]  strap_addr,
    input  logic        mdc,
    input  logic        mdio_i,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        link_up,
    input  logic        an_complete,
    input  logic        remote_fault,
    input  logic        jabber,
    input  logic [15:0] lp_ability,
    input  logic        lp_nway,
    input  logic        speed_10,
    input  logic        disconnected,
    output logic [15:0] ctrl_word
);

    localparam int AW = 5;
    localparam int DW = 16;

    logic [AW-1:0] my_addr;
    logic [AW-1:0] reg_addr;
    logic [DW-1:0] rd_data;
    logic [DW-1:0] wr_data;
    logic          rd_stb;
    logic          wr_stb;

    mdio_serial_slave #(
        .PRE_LEN (32),
        .AW      (AW),
        .DW      (DW)
    ) u_ser (
        .clk      (clk),
        .rst_n    (rst_n),
        .mdc      (mdc),
        .mdio_i   (mdio_i),
        .my_addr  (my_addr),
        .rd_data  (rd_data),
        .reg_addr (reg_addr),
        .rd_stb   (rd_stb),
        .wr_stb   (wr_stb),
        .wr_data  (wr_data),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe)
    );

    phy_reg_bank #(
        .AW (AW),
        .DW (DW)
    ) u_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .strap_addr   (strap_addr),
        .reg_addr     (reg_addr),
        .rd_stb       (rd_stb),
        .wr_stb       (wr_stb),
        .wr_data      (wr_data),
        .link_up      (link_up),
        .an_complete  (an_complete),
        .remote_fault (remote_fault),
        .jabber       (jabber),
        .lp_ability   (lp_ability),
        .lp_nway      (lp_nway),
        .speed_10     (speed_10),
        .disconnected (disconnected),
        .rd_data      (rd_data),
        .ctrl_word    (ctrl_word),
        .my_addr      (my_addr)
    );

endmodule

// File: rtl/mdio_phy_regs_chk.sv
module mdio_phy_regs_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        mdio_o,
    input logic        mdio_oe,
    input logic [15:0] ctrl_word,
    input logic [4:0]  my_addr
);

    // R6: reserved control bits never read as one
    a_r6_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_word[6:0] == 7'd0);

    // R5: zero address keeps isolate set
    a_r5_forced_isolate: assert property (@(posedge clk) disable iff (!rst_n)
        (my_addr == 5'd0) |-> ctrl_word[10]);

    // R7: soft reset bit drops after one clock
    a_r7_reset_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_word[15] |=> !ctrl_word[15]);

    // R8: restart bit drops after one clock
    a_r8_restart_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_word[9] |=> !ctrl_word[9]);

    // R2: first driven turnaround bit is zero
    a_r2_ta_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdio_oe) |-> !mdio_o);

    // R4: strapped address holds once out of reset
    a_r4_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(my_addr));

endmodule

bind mdio_phy_regs mdio_phy_regs_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .ctrl_word (ctrl_word),
    .my_addr   (my_addr)
);

// File: tb/mdio_phy_regs_test.sv
module mdio_phy_regs_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  strap_addr = 5'd5;
    logic        mdc = 1'b0;
    logic        mdio_i = 1'b1;
    logic        mdio_o;
    logic        mdio_oe;
    logic        link_up = 1'b1;
    logic        an_complete = 1'b1;
    logic        remote_fault = 1'b0;
    logic        jabber = 1'b0;
    logic [15:0] lp_ability = 16'h45E1;
    logic        lp_nway = 1'b1;
    logic        speed_10 = 1'b1;
    logic        disconnected = 1'b0;
    logic [15:0] ctrl_word;

    int nchk = 0;
    int nfail = 0;
    logic [15:0] exp_q[$];
    string       tag_q[$];
    int          mcnt = 0;
    logic [15:0] mword = '0;

    always #4 clk = ~clk;

    mdio_phy_regs uut (
        .clk(clk), .rst_n(rst_n), .strap_addr(strap_addr), .mdc(mdc),
        .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .link_up(link_up), .an_complete(an_complete),
        .remote_fault(remote_fault), .jabber(jabber),
        .lp_ability(lp_ability), .lp_nway(lp_nway), .speed_10(speed_10),
        .disconnected(disconnected), .ctrl_word(ctrl_word)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic mbit(logic b);
        mdio_i = b;
        cyc(1);
        mdc = 1'b1;
        cyc(4);
        mdc = 1'b0;
        cyc(3);
    endtask

    task automatic hdr(int pre, logic [1:0] op, logic [4:0] phy, logic [4:0] rg);
        repeat (pre) mbit(1'b1);
        mbit(1'b0);
        mbit(1'b1);
        for (int i = 1; i >= 0; i--) mbit(op[i]);
        for (int i = 4; i >= 0; i--) mbit(phy[i]);
        for (int i = 4; i >= 0; i--) mbit(rg[i]);
    endtask

    // driver: push expectation then run a read frame
    task automatic rd(logic [4:0] phy, logic [4:0] rg, logic [15:0] exp, string req);
        exp_q.push_back(exp);
        tag_q.push_back(req);
        hdr(32, 2'b10, phy, rg);
        chk({req, " R2 first turnaround released"}, {31'd0, mdio_oe}, 32'd0);
        repeat (18) mbit(1'b1);
        chk({req, " R2 line released after data"}, {31'd0, mdio_oe}, 32'd0);
    endtask

    task automatic rd_none(logic [4:0] phy, logic [4:0] rg, string req);
        logic seen;
        seen = 1'b0;
        hdr(32, 2'b10, phy, rg);
        for (int i = 0; i < 18; i++) begin
            mbit(1'b1);
            if (mdio_oe) seen = 1'b1;
        end
        chk({req, " no drive on foreign address"}, {31'd0, seen}, 32'd0);
    endtask

    task automatic wr(int pre, logic [4:0] phy, logic [4:0] rg, logic [15:0] d);
        hdr(pre, 2'b01, phy, rg);
        mbit(1'b1);
        mbit(1'b0);
        for (int i = 15; i >= 0; i--) mbit(d[i]);
        cyc(2);
    endtask

    // monitor: collects the driven turnaround zero and 16 data bits
    always @(negedge mdc) begin
        if (mdio_oe) begin
            if (mcnt == 0) begin
                chk("R2 second turnaround bit is zero", {31'd0, mdio_o}, 32'd0);
            end else begin
                mword = {mword[14:0], mdio_o};
            end
            mcnt++;
            if (mcnt == 17) begin
                mcnt = 0;
                if (exp_q.size() == 0) begin
                    chk("R2 unexpected read data", {16'd0, mword}, 32'hFFFF_FFFF);
                end else begin
                    chk(tag_q.pop_front(), {16'd0, mword}, {16'd0, exp_q.pop_front()});
                end
            end
        end
    end

    initial begin
        cyc(190000);
        nfail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        cyc(5);
        rst_n = 1'b1;
        cyc(3);
        chk("R6 reset ctrl_word", {16'd0, ctrl_word}, 32'h3000);
        rd(5, 0, 16'h3000, "R6 reset control read");
        rd(5, 1, 16'h7829, "R10 link latched low after reset");
        rd(5, 1, 16'h782D, "R9 status word");
        link_up = 1'b0;
        cyc(3);
        link_up = 1'b1;
        rd(5, 1, 16'h7829, "R10 link drop latched");
        rd(5, 1, 16'h782D, "R10 link reloaded by read");
        rd(5, 2, 16'h2000, "R11 id high");
        rd(5, 3, 16'h5C01, "R11 id low");
        rd(5, 4, 16'h01E1, "R11 advert default");
        rd(5, 5, 16'h45E1, "R11 partner ability");
        rd(5, 6, 16'h0001, "R11 expansion");
        rd(5, 25, 16'h0045, "R4 address word");
        rd(0, 25, 16'h0045, "R3 broadcast address");
        wr(32, 5, 4, 16'hFFFF);
        rd(5, 4, 16'hA3FF, "R11 advert mask");
        wr(32, 5, 0, 16'h21FF);
        chk("R6 ctrl_word after write", {16'd0, ctrl_word}, 32'h2180);
        rd(5, 0, 16'h2180, "R6 reserved bits read zero");
        wr(32, 5, 0, 16'h3300);
        rd(5, 0, 16'h3100, "R8 restart self clears");
        wr(32, 5, 0, 16'h8100);
        rd(5, 0, 16'h3000, "R7 soft reset control");
        rd(5, 4, 16'h01E1, "R7 soft reset advert");
        wr(32, 3, 4, 16'h0041);
        rd(5, 4, 16'h01E1, "R3 foreign write ignored");
        rd_none(3, 4, "R3");
        wr(32, 5, 8, 16'hFFFF);
        rd(5, 8, 16'h0000, "R12 reserved reg");
        wr(32, 5, 1, 16'h0000);
        rd(5, 1, 16'h782D, "R12 status write ignored");
        wr(32, 5, 25, 16'hFFFF);
        rd(5, 25, 16'h0045, "R12 address word write ignored");
        rd(5, 30, 16'h0000, "R12 high reserved reg");
        wr(20, 5, 0, 16'h2000);
        rd(5, 0, 16'h3000, "R1 short preamble ignored");
        speed_10 = 1'b0;
        disconnected = 1'b1;
        rd(5, 25, 16'h0025, "R4 speed and disconnect bits");
        rst_n = 1'b0;
        strap_addr = 5'd0;
        cyc(4);
        rst_n = 1'b1;
        strap_addr = 5'd9;
        cyc(3);
        chk("R5 isolate forced at reset", {16'd0, ctrl_word}, 32'h3400);
        rd(0, 25, 16'h0020, "R4 zero strap latched");
        wr(32, 0, 0, 16'h0000);
        rd(0, 0, 16'h0400, "R5 isolate not clearable");
        cyc(10);
        chk("R2 all expected reads seen", exp_q.size(), 32'd0);
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule